// File: doc/BRIEF.md
# Virtual-to-Physical Address Translator with Lookaside Cache

This block sits between a processor's address output and the memory system. It turns each virtual address into a physical address by looking the page number up in a small fully associative cache of recent translations. All tags are compared in parallel. When the lookup succeeds, the physical address comes back one clock after the request is accepted. The offset inside the page is carried straight across.

When the lookup fails, the block leaves request acceptance. It performs one memory read of the page's descriptor word, at a table base register plus four times the page number. If the descriptor says the page is resident, the block fills the cache with it and returns the translation. If not, the block returns a fault response so that the processor can raise an interrupt, and it stores nothing.

A separate invalidate input removes the cached translation for a named page when software edits that page's descriptor. When the cache is full, a new translation replaces the least recently used entry. An empty slot is always taken first.

Top module: `xlate_tlb`

## Requirements
- R1: While reset is asserted and right after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0. All cache entries start empty.
- R2: A successful response carries `rsp_paddr = {frame, offset}`. The offset is the low `PAGE_BITS` bits of the accepted virtual address, unchanged.
- R3: On a cache hit, `rsp_valid` pulses for one cycle, in the cycle after acceptance, with no memory read. `req_ready` stays 1.
- R4: On a miss, exactly one memory read is issued. `mem_req` rises in the cycle after acceptance with `mem_addr = pt_base + 4*vpn`. It holds `mem_req` and `mem_addr` steady until the cycle in which `mem_ack` is seen. `req_ready` is 0 from acceptance until the response. The response pulse follows the cycle after `mem_ack`, when `mem_req` drops.
- R5: Descriptor word layout: bit 0 is the resident flag, bit 1 is the modified flag, and bits [31:12] are the frame number. `rsp_dirty` reports the modified flag on both hits and fills.
- R6: A resident descriptor fetched on a miss is stored in the cache. The next request to that page hits.
- R7: A descriptor with resident flag 0 gives `rsp_fault = 1` with `rsp_paddr = 0` and stores nothing. A repeated request to that page walks again, and no other entry is displaced.
- R8: A fill goes to the lowest-numbered empty entry if one exists. Otherwise it goes to the least recently used entry, where both hits and fills count as use.
- R9: A cycle with `inv_valid = 1` empties the entry whose page equals `inv_vpn`. A later request to that page walks. Invalidating a page that is not cached changes nothing.
- R10: If an invalidate of the page being filled coincides with the fill cycle, the fill is dropped. The response is still returned.
- R11: No page number is ever held by more than one valid entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | VA_W | Virtual address to translate |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | PA_W | Physical address (0 on fault) |
| rsp_dirty | output | 1 | Modified flag of the page |
| rsp_fault | output | 1 | Page not resident |
| pt_base | input | PA_W | Page table base address |
| inv_valid | input | 1 | Invalidate command |
| inv_vpn | input | VA_W-PAGE_BITS | Page number to invalidate |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | PA_W | Descriptor address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | PTE_W | Descriptor word |

## Verification
The hardest states to reach are those that need a full cache with a known use order. Examples are evicting the right entry after a hit has reordered the ages, or filling an empty slot that an invalidation has opened inside an otherwise full cache. The stimulus table first fills all eight entries, then mixes hits and misses in a planned order so that every eviction has one predictable victim. Follow-up requests show which page went. The dropped fill is reached by holding the invalidate on the missing page for the whole walk, so that it overlaps the acknowledge cycle regardless of memory latency.

// File: rtl/xlate_tlb_pkg.sv
package xlate_tlb_pkg;
   // descriptor flag positions decoded by the walker
   localparam int PTE_RES_BIT = 0;
   localparam int PTE_MOD_BIT = 1;

   typedef enum logic [0:0] {
      WK_IDLE = 1'b0,
      WK_WAIT = 1'b1
   } walk_state_e;
endpackage

// File: rtl/xlate_tlb_tags.sv
module xlate_tlb_tags #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic [ENTRIES-1:0] hit_vec,
   output logic               hit_any,
   output logic [IDX_W-1:0]   hit_idx,
   output logic [PFN_W-1:0]   hit_pfn,
   output logic               hit_dirty,
   output logic [ENTRIES-1:0] valid_vec,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PFN_W-1:0]   wr_pfn,
   input  logic               wr_dirty,
   input  logic               inv_en,
   input  logic [VPN_W-1:0]   inv_vpn
);
   logic [VPN_W-1:0]   tag_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q [ENTRIES];
   logic [ENTRIES-1:0] dirty_q;
   logic [ENTRIES-1:0] valid_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
      end else begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && wr_idx == IDX_W'(i))
               valid_q[i] <= 1'b1;
            else if (inv_en && tag_q[i] == inv_vpn)
               valid_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < ENTRIES; i++) begin
         if (wr_en && wr_idx == IDX_W'(i)) begin
            tag_q[i]   <= wr_vpn;
            pfn_q[i]   <= wr_pfn;
            dirty_q[i] <= wr_dirty;
         end
      end
   end

   // one comparator per entry, all in parallel
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid_q[g] && (tag_q[g] == lk_vpn);
   end

   always_comb begin
      hit_idx   = '0;
      hit_pfn   = '0;
      hit_dirty = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (hit_vec[i]) begin
            hit_idx   = hit_idx | IDX_W'(i);
            hit_pfn   = hit_pfn | pfn_q[i];
            hit_dirty = hit_dirty | dirty_q[i];
         end
      end
   end

   assign hit_any   = |hit_vec;
   assign valid_vec = valid_q;
endmodule

// File: rtl/xlate_tlb_lru.sv
module xlate_tlb_lru #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_vec,
   input  logic               touch_en,
   input  logic [IDX_W-1:0]   touch_idx,
   output logic [IDX_W-1:0]   victim_idx
);
   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

   // ages form a permutation of 0..ENTRIES-1; 0 is most recent
   logic [IDX_W-1:0] age_q [ENTRIES];
   logic [IDX_W-1:0] touch_age;
   logic             free_found;

   assign touch_age = age_q[touch_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == touch_idx)
               age_q[i] <= '0;
            else if (age_q[i] < touch_age)
               age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      victim_idx = '0;
      free_found = 1'b0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_vec[i]) begin
            victim_idx = IDX_W'(i);
            free_found = 1'b1;
         end
      end
      if (!free_found) begin
         for (int i = 0; i < ENTRIES; i++)
            if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/xlate_tlb_walk.sv
module xlate_tlb_walk
   import xlate_tlb_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PTE_W     = 32,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PFN_W    = PA_W - PAGE_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic [VA_W-1:0]      req_vaddr,
   output logic                 req_ready,
   input  logic [PA_W-1:0]      pt_base,
   input  logic                 hit_any,
   input  logic [PFN_W-1:0]     hit_pfn,
   input  logic                 hit_dirty,
   input  logic                 inv_en,
   input  logic [VPN_W-1:0]     inv_vpn,
   output logic                 mem_req,
   output logic [PA_W-1:0]      mem_addr,
   input  logic                 mem_ack,
   input  logic [PTE_W-1:0]     mem_rdata,
   output logic                 rsp_valid,
   output logic [PA_W-1:0]      rsp_paddr,
   output logic                 rsp_dirty,
   output logic                 rsp_fault,
   output logic                 hit_touch,
   output logic                 fill_en,
   output logic [VPN_W-1:0]     fill_vpn,
   output logic [PFN_W-1:0]     fill_pfn,
   output logic                 fill_dirty
);
   walk_state_e          state_q;
   logic [VPN_W-1:0]     vpn_q;
   logic [PAGE_BITS-1:0] off_q;
   logic                 accept;
   logic                 pte_res;
   logic [PA_W-1:0]      vpn_scaled;
   logic                 unused_pte;

   assign req_ready  = (state_q == WK_IDLE);
   assign accept     = req_valid && req_ready;
   assign hit_touch  = accept && hit_any;
   assign pte_res    = mem_rdata[PTE_RES_BIT];
   assign fill_vpn   = vpn_q;
   assign fill_pfn   = mem_rdata[PTE_W-1 -: PFN_W];
   assign fill_dirty = mem_rdata[PTE_MOD_BIT];
   assign fill_en    = (state_q == WK_WAIT) && mem_ack && pte_res &&
                       !(inv_en && inv_vpn == vpn_q);
   assign vpn_scaled = PA_W'(req_vaddr[VA_W-1:PAGE_BITS]) << 2;
   assign unused_pte = ^mem_rdata;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= WK_IDLE;
         mem_req   <= 1'b0;
         mem_addr  <= '0;
         vpn_q     <= '0;
         off_q     <= '0;
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_dirty <= 1'b0;
         rsp_fault <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         unique case (state_q)
            WK_IDLE: begin
               if (accept) begin
                  off_q <= req_vaddr[PAGE_BITS-1:0];
                  vpn_q <= req_vaddr[VA_W-1:PAGE_BITS];
                  if (hit_any) begin
                     rsp_valid <= 1'b1;
                     rsp_paddr <= {hit_pfn, req_vaddr[PAGE_BITS-1:0]};
                     rsp_dirty <= hit_dirty;
                     rsp_fault <= 1'b0;
                  end else begin
                     state_q  <= WK_WAIT;
                     mem_req  <= 1'b1;
                     mem_addr <= pt_base + vpn_scaled;
                  end
               end
            end
            WK_WAIT: begin
               if (mem_ack) begin
                  state_q   <= WK_IDLE;
                  mem_req   <= 1'b0;
                  rsp_valid <= 1'b1;
                  if (pte_res) begin
                     rsp_paddr <= {fill_pfn, off_q};
                     rsp_dirty <= fill_dirty;
                     rsp_fault <= 1'b0;
                  end else begin
                     rsp_paddr <= '0;
                     rsp_dirty <= 1'b0;
                     rsp_fault <= 1'b1;
                  end
               end
            end
            default: state_q <= WK_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PTE_W     = 32,
   parameter int ENTRIES   = 8,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PFN_W    = PA_W - PAGE_BITS,
   localparam int IDX_W    = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [VA_W-1:0]  req_vaddr,
   output logic             req_ready,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic             rsp_dirty,
   output logic             rsp_fault,
   input  logic [PA_W-1:0]  pt_base,
   input  logic             inv_valid,
   input  logic [VPN_W-1:0] inv_vpn,
   output logic             mem_req,
   output logic [PA_W-1:0]  mem_addr,
   input  logic             mem_ack,
   input  logic [PTE_W-1:0] mem_rdata
);
   if (ENTRIES < 2) begin : g_bad_entries
      $error("xlate_tlb: ENTRIES must be at least 2");
   end
   if (PAGE_BITS < 2 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("xlate_tlb: PAGE_BITS out of range");
   end
   if (PTE_W < PFN_W + 2) begin : g_bad_pte
      $error("xlate_tlb: descriptor too narrow for frame and flags");
   end
   if (PA_W < VPN_W + 2) begin : g_bad_pa
      $error("xlate_tlb: PA_W cannot hold the scaled page number");
   end

   logic [ENTRIES-1:0] hit_vec;
   logic [ENTRIES-1:0] valid_vec;
   logic               hit_any;
   logic [IDX_W-1:0]   hit_idx;
   logic [PFN_W-1:0]   hit_pfn;
   logic               hit_dirty;
   logic               hit_touch;
   logic               fill_en;
   logic [VPN_W-1:0]   fill_vpn;
   logic [PFN_W-1:0]   fill_pfn;
   logic               fill_dirty;
   logic [IDX_W-1:0]   victim_idx;
   logic               touch_en;
   logic [IDX_W-1:0]   touch_idx;

   assign touch_en  = hit_touch || fill_en;
   assign touch_idx = fill_en ? victim_idx : hit_idx;

   xlate_tlb_tags #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .lk_vpn    (req_vaddr[VA_W-1:PAGE_BITS]),
      .hit_vec   (hit_vec),
      .hit_any   (hit_any),
      .hit_idx   (hit_idx),
      .hit_pfn   (hit_pfn),
      .hit_dirty (hit_dirty),
      .valid_vec (valid_vec),
      .wr_en     (fill_en),
      .wr_idx    (victim_idx),
      .wr_vpn    (fill_vpn),
      .wr_pfn    (fill_pfn),
      .wr_dirty  (fill_dirty),
      .inv_en    (inv_valid),
      .inv_vpn   (inv_vpn)
   );

   xlate_tlb_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_vec  (valid_vec),
      .touch_en   (touch_en),
      .touch_idx  (touch_idx),
      .victim_idx (victim_idx)
   );

   xlate_tlb_walk #(
      .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .PTE_W(PTE_W)
   ) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_vaddr  (req_vaddr),
      .req_ready  (req_ready),
      .pt_base    (pt_base),
      .hit_any    (hit_any),
      .hit_pfn    (hit_pfn),
      .hit_dirty  (hit_dirty),
      .inv_en     (inv_valid),
      .inv_vpn    (inv_vpn),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .rsp_valid  (rsp_valid),
      .rsp_paddr  (rsp_paddr),
      .rsp_dirty  (rsp_dirty),
      .rsp_fault  (rsp_fault),
      .hit_touch  (hit_touch),
      .fill_en    (fill_en),
      .fill_vpn   (fill_vpn),
      .fill_pfn   (fill_pfn),
      .fill_dirty (fill_dirty)
   );
endmodule

// File: rtl/xlate_tlb_chk.sv
module xlate_tlb_chk #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENTRIES   = 8,
   localparam int VPN_W    = VA_W - PAGE_BITS
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_valid,
   input logic               req_ready,
   input logic [VA_W-1:0]    req_vaddr,
   input logic [PA_W-1:0]    pt_base,
   input logic               mem_req,
   input logic [PA_W-1:0]    mem_addr,
   input logic               mem_ack,
   input logic               rsp_valid,
   input logic               rsp_fault,
   input logic [PA_W-1:0]    rsp_paddr,
   input logic [ENTRIES-1:0] hit_vec
);
   logic [PAGE_BITS-1:0] cap_off;
   logic [VPN_W-1:0]     cap_vpn;
   logic [PA_W-1:0]      cap_base;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_off  <= '0;
         cap_vpn  <= '0;
         cap_base <= '0;
      end else if (req_valid && req_ready) begin
         cap_off  <= req_vaddr[PAGE_BITS-1:0];
         cap_vpn  <= req_vaddr[VA_W-1:PAGE_BITS];
         cap_base <= pt_base;
      end
   end

   p_offset_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_fault |-> rsp_paddr[PAGE_BITS-1:0] == cap_off);

   p_walk_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> mem_addr == cap_base + (PA_W'(cap_vpn) << 2));

   p_walk_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   p_walk_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !req_ready);

   p_walk_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ack |=> !mem_req && rsp_valid);

   p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_fault |-> rsp_paddr == '0);

   p_unique_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

bind xlate_tlb xlate_tlb_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .PAGE_BITS(PAGE_BITS), .ENTRIES(ENTRIES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_ready (req_ready),
   .req_vaddr (req_vaddr),
   .pt_base   (pt_base),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_ack   (mem_ack),
   .rsp_valid (rsp_valid),
   .rsp_fault (rsp_fault),
   .rsp_paddr (rsp_paddr),
   .hit_vec   (hit_vec)
);

// File: tb/xlate_tlb_tb.sv
module xlate_tlb_tb;
   localparam logic [31:0] BASE  = 32'h0004_0000;
   localparam logic [19:0] SCRAM = 20'h5A3C0;

   typedef struct packed {
      logic [31:0] va;
      logic        walk;
      logic        fault;
   } vec_t;

   // hits and misses ordered so each eviction has one known victim (R8)
   localparam int NV = 23;
   localparam vec_t VEC [NV] = '{
      '{32'h0000_1123, 1'b1, 1'b0}, '{32'h0000_1456, 1'b0, 1'b0},
      '{32'h0000_2001, 1'b1, 1'b0}, '{32'h0000_3002, 1'b1, 1'b0},
      '{32'h0000_4003, 1'b1, 1'b0}, '{32'h0000_5004, 1'b1, 1'b0},
      '{32'h0000_6005, 1'b1, 1'b0}, '{32'h0000_7006, 1'b1, 1'b0},
      '{32'h0000_8007, 1'b1, 1'b0}, '{32'h0000_1ABC, 1'b0, 1'b0},
      '{32'h0000_9010, 1'b1, 1'b0}, '{32'h0000_1FFF, 1'b0, 1'b0},
      '{32'h0000_3000, 1'b0, 1'b0}, '{32'h0000_2777, 1'b1, 1'b0},
      '{32'h0000_4321, 1'b1, 1'b0}, '{32'h0000_3ABC, 1'b0, 1'b0},
      '{32'h0000_6111, 1'b0, 1'b0}, '{32'h0000_5222, 1'b1, 1'b0},
      '{32'h0000_8333, 1'b0, 1'b0}, '{32'h0000_7444, 1'b1, 1'b0},
      '{32'h0000_F555, 1'b1, 1'b1}, '{32'h0000_F666, 1'b1, 1'b1},
      '{32'h0000_1888, 1'b0, 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_dirty;
   logic        rsp_fault;
   logic        inv_valid = 1'b0;
   logic [19:0] inv_vpn = '0;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;

   int          n_chk = 0;
   int          n_fail = 0;
   int          walks = 0;
   logic [19:0] cur_vpn = '0;

   always #10 clk = ~clk;

   xlate_tlb u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
      .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
      .rsp_dirty(rsp_dirty), .rsp_fault(rsp_fault), .pt_base(BASE),
      .inv_valid(inv_valid), .inv_vpn(inv_vpn), .mem_req(mem_req),
      .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
   );

   // page table model: low nibble F means not resident, bit0 of page is modified flag
   function automatic logic [31:0] pte_of(input logic [19:0] vpn);
      return {vpn ^ SCRAM, 10'b0, vpn[0], (vpn[3:0] != 4'hF)};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory responder with varying latency
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req) begin
            walks++;
            check(mem_addr == BASE + {10'b0, cur_vpn, 2'b00}, "R4", "walk address",
                  mem_addr, BASE + {10'b0, cur_vpn, 2'b00});
            repeat (walks % 3) @(negedge clk);
            check(mem_req == 1'b1, "R4", "request held", {31'b0, mem_req}, 32'd1);
            mem_rdata = pte_of(cur_vpn);
            mem_ack   = 1'b1;
            @(negedge clk);
            mem_ack   = 1'b0;
         end
      end
   end

   task automatic run(input logic [31:0] va, input bit ew, input bit ef, input string tag);
      int          cyc;
      int          w0;
      logic [31:0] pte;
      logic [31:0] exp_pa;
      w0  = walks;
      pte = pte_of(va[31:12]);
      @(negedge clk);
      cur_vpn   = va[31:12];
      req_valid = 1'b1;
      req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      check(req_ready == !ew, ew ? "R4" : "R3", {tag, " ready after accept"},
            {31'b0, req_ready}, {31'b0, !ew});
      cyc = 1;
      while (!rsp_valid && cyc < 40) begin
         @(negedge clk);
         cyc++;
      end
      exp_pa = ef ? 32'h0 : {pte[31:12], va[11:0]};
      check(rsp_valid == 1'b1, "R3", {tag, " response seen"}, {31'b0, rsp_valid}, 32'd1);
      check((walks - w0) == int'(ew), ew ? "R6" : "R8", {tag, " walk count"},
            walks - w0, {31'b0, ew});
      if (!ew)
         check(cyc == 1, "R3", {tag, " hit latency"}, cyc, 32'd1);
      check(rsp_fault == ef, "R7", {tag, " fault"}, {31'b0, rsp_fault}, {31'b0, ef});
      check(rsp_paddr == exp_pa, "R2", {tag, " paddr"}, rsp_paddr, exp_pa);
      if (!ef)
         check(rsp_dirty == pte[1], "R5", {tag, " modified flag"},
               {31'b0, rsp_dirty}, {31'b0, pte[1]});
      @(negedge clk);
      check(rsp_valid == 1'b0, "R3", {tag, " single pulse"}, {31'b0, rsp_valid}, 32'd0);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      check(req_ready == 1'b1, "R1", "ready in reset", {31'b0, req_ready}, 32'd1);
      check(rsp_valid == 1'b0, "R1", "no response in reset", {31'b0, rsp_valid}, 32'd0);
      check(mem_req == 1'b0, "R1", "no walk in reset", {31'b0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && !mem_req && !rsp_valid, "R1", "idle after reset",
            {29'b0, req_ready, mem_req, rsp_valid}, 32'h4);

      for (int i = 0; i < NV; i++)
         run(VEC[i].va, VEC[i].walk, VEC[i].fault, $sformatf("vec%0d", i));

      // R9: invalidating an absent page leaves entries alone
      @(negedge clk);
      inv_valid = 1'b1; inv_vpn = 20'h00077;
      @(negedge clk);
      inv_valid = 1'b0;
      run(32'h0000_1234, 1'b0, 1'b0, "R9 absent inv");

      // R9: invalidate a cached page, then it walks; R8: refill takes the freed slot
      @(negedge clk);
      inv_valid = 1'b1; inv_vpn = 20'h00003;
      @(negedge clk);
      inv_valid = 1'b0;
      run(32'h0000_3999, 1'b1, 1'b0, "R9 inv page walks");
      run(32'h0000_2AAA, 1'b0, 1'b0, "R8 free slot first");

      // R10: invalidate held across the fill of the same page drops the fill
      @(negedge clk);
      inv_valid = 1'b1; inv_vpn = 20'h00020;
      run(32'h0002_0044, 1'b1, 1'b0, "R10 fill vs inv");
      inv_valid = 1'b0;
      run(32'h0000_4010, 1'b0, 1'b0, "R10 nothing evicted");
      run(32'h0002_0055, 1'b1, 1'b0, "R10 page walks again");
      run(32'h0002_0066, 1'b0, 1'b0, "R6 refilled page hits");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule